// File: doc/BRIEF.md
# Execute Packet Dispatcher for a Wide-Issue Core

This block sits between instruction fetch and the functional units of a wide-issue processor. Fetch delivers a fixed-width fetch packet of eight 32-bit instruction words in one handshake. Each word carries a chaining flag. When the flag is set, the following word issues in the same cycle. When it is clear, the following word waits for a later cycle. The dispatcher holds the fetch packet and walks a slot pointer through it. In each cycle it sends one execute packet to the functional units. Each word goes to the unit named by a small field inside the word.

A fetch packet can drain in one cycle if every word is chained, or in as many as eight cycles if none is. While a packet is draining, fetch is held off. Two words of one execute packet may name the same unit. In that case the block withholds both of them, lets the rest of the packet issue, and flags the clash for that cycle.

Top module: `epd_dispatch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `fp_ready` is 1 and `unit_valid` and `pack_err` are 0.
- R2: `fp_ready` is 1 only when no fetch packet is held. After a handshake (`fp_valid` and `fp_ready` both 1 at a rising edge), `fp_ready` stays 0 until the cycle in which the last execute packet of that fetch packet appears on the outputs. While `fp_ready` is 0, `fp_valid` and `fp_data` have no effect.
- R3: Slot s of `fp_data` occupies bits [32s+31:32s], and slot 0 issues first. Bit 0 of a word is the chaining flag. A value of 1 puts the next slot in the same execute packet. A value of 0 ends the execute packet at this word.
- R4: Slot 7 always ends its execute packet, whatever its chaining flag says. An execute packet never takes words from two fetch packets.
- R5: Bits [3:1] of a word name the target unit u (0 to 7). A word that issues drives `unit_valid[u]` to 1 and drives `unit_insn[32u+31:32u]` with the whole 32-bit word.
- R6: A unit that receives no word in a cycle has `unit_valid` 0 and its `unit_insn` field all zero.
- R7: If two or more words of one execute packet name the same unit, none of those words issue: that unit's `unit_valid` stays 0. `pack_err` is 1 for that cycle, and the other words of the packet still issue.
- R8: Suppose a fetch packet is accepted at rising edge t. Its k-th execute packet (k counted from 0) is shown on the outputs during the cycle after edge t+1+k.
- R9: Dispatch outputs last exactly one cycle. In any cycle that follows a cycle with `fp_ready` at 1, `unit_valid` is all zero and `pack_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_valid | input | 1 | A fetch packet is offered |
| fp_data | input | 256 | Eight 32-bit instruction words, slot 0 in the low bits |
| fp_ready | output | 1 | The dispatcher can take a fetch packet |
| unit_valid | output | 8 | One strobe per functional unit for this cycle |
| unit_insn | output | 256 | The word sent to each unit, unit u at bits [32u+31:32u] |
| pack_err | output | 1 | Two or more words of this cycle's execute packet named the same unit |

## Verification
The final execute packet of a fetch packet and the reopening of fetch happen in the same cycle: the last dispatch strobes are visible while `fp_ready` is already high. The bench keeps `fp_valid` asserted back to back, with fresh data offered even while the block is draining. It then checks that the waiting packet is taken exactly at that edge, and that the data offered during the drain never reaches a unit. A clash and a normal issue can also share a cycle. Packets mixing duplicated and distinct unit fields are compared on every clock against a behavioural queue model, both for the withheld unit and for the units that still fire.

// File: rtl/epd_pkg.sv
package epd_pkg;
  parameter int unsigned SLOTS_D     = 8;
  parameter int unsigned WORD_W_D    = 32;
  parameter int unsigned UNITS_D     = 8;
  parameter int unsigned CHAIN_POS_D = 0;
  parameter int unsigned UNIT_LSB_D  = 1;

  typedef enum logic {
    FILL_EMPTY = 1'b0,
    FILL_DRAIN = 1'b1
  } fill_e;
endpackage

// File: rtl/epd_span.sv
// Finds the slots that form the execute packet starting at the slot pointer.
module epd_span #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned PW   = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] chain,
  input  logic [PW-1:0]    ptr,
  output logic [SLOTS-1:0] member,
  output logic [PW-1:0]    last,
  output logic             tail
);
  logic stop;

  always_comb begin
    member = '0;
    last   = ptr;
    stop   = 1'b0;
    for (int i = 0; i < int'(SLOTS); i++) begin
      if (!stop && (i >= int'(ptr))) begin
        member[i] = 1'b1;
        last      = PW'(i);
        if (!chain[i] || (i == int'(SLOTS) - 1)) begin
          stop = 1'b1;
        end
      end
    end
    tail = member[SLOTS-1];
  end
endmodule

// File: rtl/epd_route.sv
// Steers member words to their units; units named twice or more are withheld.
module epd_route #(
  parameter int unsigned SLOTS    = 8,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned UNITS    = 8,
  parameter int unsigned UNIT_LSB = 1,
  localparam int unsigned UW      = $clog2(UNITS),
  localparam int unsigned CW      = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS*WORD_W-1:0] words,
  input  logic [SLOTS-1:0]        member,
  output logic [UNITS-1:0]        uv,
  output logic [UNITS*WORD_W-1:0] ui,
  output logic                    clash_any
);
  logic [UNITS-1:0] clash;

  for (genvar u = 0; u < int'(UNITS); u++) begin : g_unit
    logic [CW-1:0]     hits;
    logic [WORD_W-1:0] pick;

    always_comb begin
      hits = '0;
      pick = '0;
      for (int s = 0; s < int'(SLOTS); s++) begin
        if (member[s] && (words[s*WORD_W+UNIT_LSB +: UW] == UW'(u))) begin
          hits = hits + CW'(1);
          pick = words[s*WORD_W +: WORD_W];
        end
      end
      uv[u]                 = (hits == CW'(1));
      ui[u*WORD_W +: WORD_W] = (hits == CW'(1)) ? pick : '0;
      clash[u]              = (hits > CW'(1));
    end
  end

  assign clash_any = |clash;
endmodule

// File: rtl/epd_dispatch.sv
module epd_dispatch #(
  parameter int unsigned SLOTS     = epd_pkg::SLOTS_D,
  parameter int unsigned WORD_W    = epd_pkg::WORD_W_D,
  parameter int unsigned UNITS     = epd_pkg::UNITS_D,
  parameter int unsigned CHAIN_POS = epd_pkg::CHAIN_POS_D,
  parameter int unsigned UNIT_LSB  = epd_pkg::UNIT_LSB_D,
  localparam int unsigned PW       = $clog2(SLOTS),
  localparam int unsigned FPW      = SLOTS * WORD_W,
  localparam int unsigned UOW      = UNITS * WORD_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fp_valid,
  input  logic [FPW-1:0] fp_data,
  output logic           fp_ready,
  output logic [UNITS-1:0] unit_valid,
  output logic [UOW-1:0] unit_insn,
  output logic           pack_err
);
  import epd_pkg::*;

  fill_e            state_q, state_n;
  logic [FPW-1:0]   buf_q;
  logic             buf_en;
  logic [PW-1:0]    ptr_q, ptr_n;
  logic [UNITS-1:0] uv_q, uv_n;
  logic [UOW-1:0]   ui_q, ui_n;
  logic             err_q, err_n;

  logic [SLOTS-1:0] chain;
  logic [SLOTS-1:0] member;
  logic [PW-1:0]    last;
  logic             tail;
  logic [UNITS-1:0] r_uv;
  logic [UOW-1:0]   r_ui;
  logic             r_err;

  for (genvar s = 0; s < int'(SLOTS); s++) begin : g_chain
    assign chain[s] = buf_q[s*WORD_W + CHAIN_POS];
  end

  epd_span #(.SLOTS(SLOTS)) u_span (
    .chain  (chain),
    .ptr    (ptr_q),
    .member (member),
    .last   (last),
    .tail   (tail)
  );

  epd_route #(
    .SLOTS(SLOTS), .WORD_W(WORD_W), .UNITS(UNITS), .UNIT_LSB(UNIT_LSB)
  ) u_route (
    .words     (buf_q),
    .member    (member),
    .uv        (r_uv),
    .ui        (r_ui),
    .clash_any (r_err)
  );

  assign fp_ready = (state_q == FILL_EMPTY);

  always_comb begin
    state_n = state_q;
    ptr_n   = ptr_q;
    buf_en  = 1'b0;
    uv_n    = '0;
    ui_n    = '0;
    err_n   = 1'b0;
    if (state_q == FILL_DRAIN) begin
      uv_n  = r_uv;
      ui_n  = r_ui;
      err_n = r_err;
      if (tail) begin
        state_n = FILL_EMPTY;
        ptr_n   = '0;
      end else begin
        ptr_n = last + PW'(1);
      end
    end else if (fp_valid) begin
      buf_en  = 1'b1;
      state_n = FILL_DRAIN;
      ptr_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FILL_EMPTY;
      ptr_q   <= '0;
      uv_q    <= '0;
      ui_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      ptr_q   <= ptr_n;
      uv_q    <= uv_n;
      ui_q    <= ui_n;
      err_q   <= err_n;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_en) begin
      buf_q <= fp_data;
    end
  end

  assign unit_valid = uv_q;
  assign unit_insn  = ui_q;
  assign pack_err   = err_q;

  // R2: a taken fetch packet closes the fetch handshake on the next cycle
  p_hold_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_valid && fp_ready) |=> !fp_ready);

  // R9: nothing is dispatched in the cycle after the buffer was empty
  p_quiet_when_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fp_ready |=> ((unit_valid == '0) && !pack_err));

  // R4: a pointer sitting on the last slot always finishes the fetch packet
  p_tail_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == FILL_DRAIN) && (ptr_q == PW'(SLOTS - 1))) |=> fp_ready);

  // R3: while draining, the slot pointer only moves forward or the packet ends
  p_ptr_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FILL_DRAIN) |=> (fp_ready || (ptr_q > $past(ptr_q))));
endmodule

// File: tb/tb_epd_dispatch.sv
`timescale 1ns/1ps
module tb_epd_dispatch;
  localparam int NS = 8;
  localparam int NU = 8;

  logic          clk;
  logic          rst_n;
  logic          fp_valid;
  logic [255:0]  fp_data;
  logic          fp_ready;
  logic [7:0]    unit_valid;
  logic [255:0]  unit_insn;
  logic          pack_err;

  epd_dispatch dut (
    .clk(clk), .rst_n(rst_n), .fp_valid(fp_valid), .fp_data(fp_data),
    .fp_ready(fp_ready), .unit_valid(unit_valid), .unit_insn(unit_insn),
    .pack_err(pack_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference state
  logic [31:0]  m_buf [NS];
  bit           m_busy;
  int           m_ptr;
  logic [7:0]   e_uv;
  logic [255:0] e_ui;
  bit           e_err;
  bit           e_ready;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input int unit, input bit ch, input int tag);
    return {tag[27:0], unit[2:0], ch};
  endfunction

  task automatic model_edge(input bit v, input logic [255:0] d);
    int cnt [NU];
    logic [31:0] pk [NU];
    int j;
    bit fin;
    e_uv = '0; e_ui = '0; e_err = 1'b0;
    if (m_busy) begin
      for (int u = 0; u < NU; u++) begin cnt[u] = 0; pk[u] = '0; end
      j = m_ptr; fin = 1'b0;
      while (!fin) begin
        cnt[m_buf[j][3:1]]++;
        pk[m_buf[j][3:1]] = m_buf[j];
        if (j == NS - 1 || m_buf[j][0] == 1'b0) fin = 1'b1;
        else j++;
      end
      for (int u = 0; u < NU; u++) begin
        if (cnt[u] == 1) begin e_uv[u] = 1'b1; e_ui[u*32 +: 32] = pk[u]; end
        if (cnt[u] > 1) e_err = 1'b1;
      end
      if (j == NS - 1) m_busy = 1'b0;
      else m_ptr = j + 1;
    end else if (v) begin
      for (int s = 0; s < NS; s++) m_buf[s] = d[s*32 +: 32];
      m_busy = 1'b1;
      m_ptr  = 0;
    end
    e_ready = !m_busy;
  endtask

  // one clock: compare at the falling edge, then drive and advance the model
  task automatic step(input bit v, input logic [255:0] d, output bit taken);
    @(negedge clk);
    chk("R2 fp_ready", {255'd0, fp_ready}, {255'd0, e_ready});
    chk("R3 R4 R5 R6 R7 R8 R9 unit_valid", {248'd0, unit_valid}, {248'd0, e_uv});
    chk("R5 R6 unit_insn", unit_insn, e_ui);
    chk("R7 pack_err", {255'd0, pack_err}, {255'd0, e_err});
    taken = v && e_ready;
    fp_valid = v;
    fp_data  = d;
    model_edge(v, d);
  endtask

  task automatic send(input logic [255:0] d);
    bit t;
    t = 1'b0;
    while (!t) step(1'b1, d, t);
  endtask

  task automatic idle(input int n);
    bit t;
    for (int i = 0; i < n; i++) step(1'b0, '0, t);
  endtask

  function automatic logic [255:0] pack8(input logic [31:0] w [NS]);
    logic [255:0] r;
    for (int s = 0; s < NS; s++) r[s*32 +: 32] = w[s];
    return r;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] w [NS];
    bit t;
    rst_n = 1'b0; fp_valid = 1'b0; fp_data = '0;
    m_busy = 1'b0; m_ptr = 0; e_uv = '0; e_ui = '0; e_err = 1'b0; e_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 fp_ready", {255'd0, fp_ready}, 256'd1);
    chk("R1 unit_valid", {248'd0, unit_valid}, 256'd0);
    chk("R1 pack_err", {255'd0, pack_err}, 256'd0);
    rst_n = 1'b1;
    idle(2);

    // R3: no chaining, eight single-word execute packets, units reversed
    for (int s = 0; s < NS; s++) w[s] = mk(7 - s, 1'b0, 16'h100 + s);
    send(pack8(w));
    idle(10);

    // R3 R5: full chain, one packet of eight distinct units
    for (int s = 0; s < NS; s++) w[s] = mk((s * 3) % 8, 1'b1, 16'h200 + s);
    send(pack8(w));
    idle(3);

    // R4: slot 7 chained still closes; R2: new data offered during the drain
    for (int s = 0; s < NS; s++) w[s] = mk(s, (s != 2), 16'h300 + s);
    send(pack8(w));
    for (int s = 0; s < NS; s++) w[s] = mk(s, 1'b0, 16'h400 + s);
    send(pack8(w));          // offered while busy, taken as the drain ends
    send(pack8(w) ^ {8{32'h0001_0000}});  // back to back
    idle(12);

    // R7: unit clash inside a packet, other words still issue
    w[0] = mk(2, 1'b1, 16'h501); w[1] = mk(5, 1'b1, 16'h502);
    w[2] = mk(2, 1'b0, 16'h503); w[3] = mk(4, 1'b1, 16'h504);
    w[4] = mk(4, 1'b1, 16'h505); w[5] = mk(4, 1'b0, 16'h506);
    w[6] = mk(1, 1'b0, 16'h507); w[7] = mk(1, 1'b1, 16'h508);
    send(pack8(w));
    idle(8);

    // R8 R9: pseudo-random mix with gaps
    for (int p = 0; p < 60; p++) begin
      for (int s = 0; s < NS; s++) w[s] = $urandom;
      send(pack8(w));
      if ((p % 4) == 0) idle(int'($urandom % 3));
    end
    idle(12);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule